// File: doc/BRIEF.md
# Logarithmic Programmable Barrel Shifter

This block is a purely combinational word shifter for a processor datapath. The shift unit sits beside the ALU rather than inside it. It takes a data word, a shift count, a direction select and a fill-type select, and returns the shifted word in the same cycle. Any count from zero up to one less than the word width is supported.

The structure is a chain of stages, one per bit of the shift count. Stage k either passes its input unchanged or moves it by 2^k places. The direction and fill controls are shared by every stage. The fill bit for vacated positions is worked out once, from the sign bit of the original input. An intermediate stage's sign bit is never used, so all stages fill with the same value. An arithmetic left shift puts zeros into the vacated low bits, exactly as a logical left shift does.

Top module: `lshift_barrel`

## Requirements
- R1: With `to_right`=0 and `keep_sign`=0, `dout` equals `din` shifted toward the MSB by `amt` places, with zeros entering at bit 0, for every `amt` from 0 to 31.
- R2: With `to_right`=1 and `keep_sign`=0, `dout` equals `din` shifted toward the LSB by `amt` places, with zeros entering at bit 31.
- R3: With `to_right`=1 and `keep_sign`=1, `dout` equals `din` shifted toward the LSB by `amt` places, and every vacated high position holds the value of `din[31]`.
- R4: With `to_right`=0 and `keep_sign`=1, the result is identical to the R1 result for the same `din` and `amt`; zeros fill the low bits.
- R5: When `amt` is 0, `dout` equals `din` for all four settings of `to_right` and `keep_sign`.
- R6: Bit k of `amt` adds a move of exactly 2^k places (1, 2, 4, 8 or 16). An amount with a single bit set gives exactly that distance, and the stage for a clear bit does not change its word.
- R7: At the largest count (31), a logical shift in either direction leaves at most one bit of `din` in the word. An arithmetic right shift gives all ones when `din[31]`=1 and all zeros when it is 0.
- R8: The block holds no state. A change on any input shows up on `dout` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to be shifted |
| amt | input | 5 | Shift distance, 0 to 31 |
| to_right | input | 1 | 0 = shift toward MSB, 1 = shift toward LSB |
| keep_sign | input | 1 | 0 = zero fill, 1 = sign fill on right shifts |
| dout | output | 32 | Shifted word |

## Verification
Every result of this block is due in the cycle its inputs change, because no register lies between any input and `dout`. The bench changes its inputs 1 ns after a rising clock edge and samples `dout` at the next falling edge, half a period later. Each compare therefore sees inputs that have settled and are not yet replaced. A behavioural model moves the word one place per loop pass and computes the expected value for the same inputs. That model is compared on every clock while stimulus is active.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic { SHF_LEFT = 1'b0, SHF_RIGHT = 1'b1 } shf_dir_e;
  typedef enum logic { SHF_ZERO = 1'b0, SHF_SIGN  = 1'b1 } shf_fill_e;

  // Value shifted into vacated places: the sign only for right sign-fill shifts.
  function automatic logic fill_value(logic to_right, logic keep_sign, logic sign);
    return (to_right == SHF_RIGHT) && (keep_sign == SHF_SIGN) && sign;
  endfunction

  // Per-bit selection of one stage: own bit, lower neighbour or upper neighbour.
  function automatic logic pick_bit(logic en, logic to_right,
                                    logic own, logic from_low, logic from_high);
    if (!en) return own;
    return to_right ? from_high : from_low;
  endfunction
endpackage

// File: rtl/shf_fill.sv
module shf_fill (
  input  logic to_right,
  input  logic keep_sign,
  input  logic sign_in,
  output logic fill
);
  import shf_pkg::*;
  always_comb fill = fill_value(to_right, keep_sign, sign_in);
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int DATA_W = 32,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] d_in,
  input  logic              en,
  input  logic              to_right,
  input  logic              fill,
  output logic [DATA_W-1:0] d_out
);
  import shf_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic low_src;
    logic high_src;
    if (i >= DIST) begin : g_low_in
      assign low_src = d_in[i-DIST];
    end else begin : g_low_zero
      assign low_src = 1'b0;
    end
    if (i + DIST < DATA_W) begin : g_high_in
      assign high_src = d_in[i+DIST];
    end else begin : g_high_fill
      assign high_src = fill;
    end
    assign d_out[i] = pick_bit(en, to_right, d_in[i], low_src, high_src);
  end
endmodule

// File: rtl/lshift_barrel.sv
module lshift_barrel #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              to_right,
  input  logic              keep_sign,
  output logic [DATA_W-1:0] dout
);
  logic                         fill_bit;
  logic [AMT_W:0][DATA_W-1:0]   stage_q;

  shf_fill u_fill (
    .to_right (to_right),
    .keep_sign(keep_sign),
    .sign_in  (din[DATA_W-1]),
    .fill     (fill_bit)
  );

  assign stage_q[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shf_stage #(.DATA_W(DATA_W), .DIST(1 << k)) u_stage (
      .d_in    (stage_q[k]),
      .en      (amt[k]),
      .to_right(to_right),
      .fill    (fill_bit),
      .d_out   (stage_q[k+1])
    );
  end

  assign dout = stage_q[AMT_W];
endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input logic [DATA_W-1:0]               din,
  input logic [AMT_W-1:0]                amt,
  input logic                            to_right,
  input logic                            keep_sign,
  input logic [DATA_W-1:0]               dout,
  input logic [AMT_W:0][DATA_W-1:0]      stage_q
);
  always_comb begin
    if (!$isunknown({din, amt, to_right, keep_sign})) begin
      // R5
      if (amt == '0) pass_zero_chk: assert (dout == din);
      // R1
      if (!to_right && amt != '0) left_lsb_zero_chk: assert (dout[0] == 1'b0);
      // R2
      if (to_right && !keep_sign && amt != '0) logic_msb_zero_chk: assert (dout[DATA_W-1] == 1'b0);
      // R3
      if (to_right && keep_sign) arith_sign_chk: assert (dout[DATA_W-1] == din[DATA_W-1]);
      // R2
      if (!(to_right && keep_sign)) ones_not_grow_chk: assert ($countones(dout) <= $countones(din));
      for (int k = 0; k < AMT_W; k++) begin
        // R6
        if (!amt[k]) stage_hold_chk: assert (stage_q[k+1] == stage_q[k]);
        // R6
        if (amt[k] && !to_right) stage_left_chk: assert (stage_q[k+1][1 << k] == stage_q[k][0]);
        // R6
        if (amt[k] && to_right) stage_right_chk: assert (stage_q[k+1][0] == stage_q[k][1 << k]);
      end
    end
  end
endmodule

bind lshift_barrel shf_barrel_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .din      (din),
  .amt      (amt),
  .to_right (to_right),
  .keep_sign(keep_sign),
  .dout     (dout),
  .stage_q  (stage_q)
);

// File: tb/sim_lshift_barrel.sv
`timescale 1ns/1ps
module sim_lshift_barrel;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [4:0]    amt = '0;
  logic          to_right = 1'b0;
  logic          keep_sign = 1'b0;
  logic [DW-1:0] dout;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles = 0;
  bit    active = 1'b0;
  string cur_req = "R5";

  lshift_barrel u0 (.din(din), .amt(amt), .to_right(to_right), .keep_sign(keep_sign), .dout(dout));

  always #5 clk = ~clk;

  // One place per pass, fill taken from the unshifted input.
  function automatic logic [DW-1:0] model(input logic [DW-1:0] d, input int n,
                                          input bit r, input bit a);
    logic [DW-1:0] v = d;
    bit sgn = d[DW-1];
    for (int i = 0; i < n; i++)
      v = r ? {(a ? sgn : 1'b0), v[DW-1:1]} : {v[DW-2:0], 1'b0};
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && active) begin
      logic [DW-1:0] exp_v;
      exp_v = model(din, int'(amt), to_right, keep_sign);
      n_checks++;
      if (dout !== exp_v) begin
        n_errors++;
        $display("FAIL %s din=%h amt=%0d r=%0b a=%0b actual %h expected %h",
                 cur_req, din, amt, to_right, keep_sign, dout, exp_v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_errors++;
      $display("FAIL R8 watchdog actual %0d cycles expected under 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  function automatic string tag_for(input logic [4:0] a, input bit r, input bit k);
    if (a == 0) return "R5";
    if (a == 31) return "R7";
    if ($onehot(a)) return "R6";
    if (!r) return k ? "R4" : "R1";
    return k ? "R3" : "R2";
  endfunction

  task automatic apply(input logic [DW-1:0] d, input logic [4:0] a, input bit r, input bit k);
    @(posedge clk);
    #1;
    din = d; amt = a; to_right = r; keep_sign = k;
    cur_req = tag_for(a, r, k);
    active = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R5: idle inputs pass straight through
    apply('0, 5'd0, 1'b0, 1'b0);
    for (int m = 0; m < 4; m++) begin
      apply(32'hDEAD_BEEF, 5'd0, m[1], m[0]);       // R5
      apply(32'h8000_0001, 5'd31, m[1], m[0]);      // R7
      apply(32'h7FFF_FFFE, 5'd31, m[1], m[0]);      // R7
      for (int s = 0; s < 5; s++)
        apply(32'hC35A_0F81, 5'(1 << s), m[1], m[0]); // R6
    end
    // R1, R4 sweep across all counts
    for (int n = 0; n < 32; n++) begin
      apply(32'h9ABC_DEF1, 5'(n), 1'b0, 1'b0);
      apply(32'h9ABC_DEF1, 5'(n), 1'b0, 1'b1);
      apply(32'h9ABC_DEF1, 5'(n), 1'b1, 1'b0);      // R2
      apply(32'h9ABC_DEF1, 5'(n), 1'b1, 1'b1);      // R3
      apply(32'h1234_5678, 5'(n), 1'b1, 1'b1);      // R3 positive sign
    end
    // R8: change inputs within one cycle, result follows the same cycle
    apply(32'hFFFF_0000, 5'd4, 1'b1, 1'b1);
    cur_req = "R8";
    #1 din = 32'h0000_FFFF;
    @(negedge clk);
    #1;
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] d;
      logic [4:0] a;
      d = $urandom;
      a = 5'($urandom_range(0, 31));
      apply(d, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    active = 1'b0;
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule